// File: doc/BRIEF.md
# Watchdog Timer with Vector-Overlapped Clear

This block is a watchdog that counts internal-clock cycles while it is enabled. Software must service it before a selectable timeout runs out. If it does not, the block raises a one-cycle system reset request. The watchdog never requests an interrupt; reset is its only action. Software services it by writing any value to the top address of the memory map. The same address serves as the reset vector on reads, so a read there returns a supplied low byte of that vector and has no effect on the count.

The timeout is a power of two minus a small power of two. One exponent is short and the other is long, and the choice comes from a rate-select input; a low rate-select gives the long period. Three things can disable the watchdog. The first is a disable input. The second is a sticky lock, set when monitor mode is entered under high test voltage, which only power-on reset clears. The third is a level condition: monitor mode entered through blank vectors while the test voltage is still present. The configuration register that holds rate-select and disable lives outside the block, and reset clears it, so after reset the long timeout is in force.

Top module: `wdt_vector_cop`

## Requirements
- R1: With `rate_short` = 1, `cop_rst_req` goes high exactly 2^SHORT_EXP − 2^SUB_EXP enabled clock edges after the counter last restarted.
- R2: With `rate_short` = 0, which is the value the cleared configuration register supplies after reset, the timeout is 2^LONG_EXP − 2^SUB_EXP enabled edges.
- R3: A write (`bus_wr` = 1) to the all-ones address clears the counter and starts a full new period. A write to any other address has no effect on the timing.
- R4: While `bus_rd` = 1 and the address is all ones, `rd_data` equals `rst_vec_lo`. Otherwise `rd_data` is 0. Reads never change the count.
- R5: While `cop_dis` = 1 the counter holds its value and no request is raised. When `cop_dis` returns to 0, counting resumes from the held value.
- R6: `cop_rst_req` is high for exactly one cycle. The counter then restarts from zero, so expiries repeat once per period.
- R7: A service write on the edge where the count would expire takes priority. No request is raised and a full period starts.
- R8: `rst_n` low clears the counter and holds `cop_rst_req` low, and a full period starts after release.
- R9: A one-cycle `mon_hv_entry` pulse disables the watchdog until `por_n` is asserted. `rst_n` alone does not re-enable it.
- R10: While `mon_blank` = 1 and `tst_hv` = 1 the watchdog is held. `tst_hv` alone, or `mon_blank` alone, does not disable it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock that the count advances on |
| rst_n | input | 1 | System reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low, clears the monitor lock |
| rate_short | input | 1 | 1 selects the short timeout, 0 the long one |
| cop_dis | input | 1 | 1 disables the watchdog |
| mon_hv_entry | input | 1 | Pulse: monitor mode entered with high test voltage |
| mon_blank | input | 1 | Level: monitor mode entered through blank vectors |
| tst_hv | input | 1 | Level: high test voltage currently present |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| rst_vec_lo | input | VEC_W | Low byte of the reset vector, returned on reads |
| cop_rst_req | output | 1 | One-cycle reset request on expiry |
| rd_data | output | VEC_W | Read data for the top address |

## Verification
The bench uses a reduced configuration so that both timeouts can be measured edge by edge. It sweeps service points across the period, including the expiry edge itself. A design with an off-by-one terminal count would miss the exact period. A design that gave expiry priority over service would fire a reset even though software had just written. The bench also writes to near-miss addresses and reads the vector during a count. An incomplete address decode would clear the counter too early, and a read that cleared the counter would stretch the period. For the disable paths, a counter that resets instead of holding shows up as a longer delay after release. A monitor lock that `rst_n` clears would let the watchdog fire before power-on reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Period in clock edges: a power of two less a small power of two.
  function automatic int unsigned timeout_cycles(input int unsigned big_exp,
                                                 input int unsigned small_exp);
    return (32'd1 << big_exp) - (32'd1 << small_exp);
  endfunction

  // Reasons the count may be held.
  typedef struct packed {
    logic by_cfg;    // configuration disable bit
    logic by_lock;   // sticky high-voltage monitor lock
    logic by_probe;  // blank-vector monitor with test voltage present
  } wdt_hold_t;

endpackage

// File: rtl/wdt_bus_port.sv
module wdt_bus_port #(
  parameter int ADDR_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [VEC_W-1:0]  rst_vec_lo,
  output logic              svc,
  output logic [VEC_W-1:0]  rd_data
);

  logic top_hit;

  // Top of the memory map: every address bit set.
  assign top_hit = &bus_addr;
  assign svc     = bus_wr && top_hit;
  assign rd_data = (bus_rd && top_hit) ? rst_vec_lo : '0;

endmodule

// File: rtl/wdt_gate.sv
module wdt_gate
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  logic      cop_dis,
  input  logic      mon_hv_entry,
  input  logic      mon_blank,
  input  logic      tst_hv,
  output wdt_hold_t hold,
  output logic      run
);

  logic lock_q;

  // Sticky lock: only power-on reset releases it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            lock_q <= 1'b0;
    else if (mon_hv_entry) lock_q <= 1'b1;
  end

  always_comb begin
    hold.by_cfg   = cop_dis;
    hold.by_lock  = lock_q;
    hold.by_probe = mon_blank && tst_hv;
    run           = !(hold.by_cfg || hold.by_lock || hold.by_probe);
  end

  // R9: once set, the lock survives until power-on reset
  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |=> lock_q);

  // R9: an entry pulse always leaves the watchdog held on the next cycle
  p_entry_locks_r9: assert property (@(posedge clk) disable iff (!por_n)
    mon_hv_entry |=> !run);

endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core #(
  parameter int CNT_W = 18,
  parameter logic [CNT_W-1:0] LONG_T  = '1,
  parameter logic [CNT_W-1:0] SHORT_T = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic svc,
  input  logic rate_short,
  output logic expire_q
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term_sel;
  logic             at_last;

  assign term_sel = rate_short ? SHORT_T : LONG_T;
  // >= guards against a rate switch that leaves the count past the new end.
  assign at_last  = (cnt_q >= (term_sel - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (svc) begin
        cnt_q <= '0;
      end else if (run) begin
        if (at_last) begin
          cnt_q    <= '0;
          expire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R6: the request lasts a single cycle
  p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |=> !expire_q);

  // R3 / R7: a service write clears the count and no request follows
  p_svc_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> (cnt_q == '0) && !expire_q);

  // R5: a held counter neither moves nor fires
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !svc) |=> ($stable(cnt_q) && !expire_q));

  // R2: the count never reaches the long terminal value
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < LONG_T);

endmodule

// File: rtl/wdt_vector_cop.sv
module wdt_vector_cop #(
  parameter int ADDR_W    = 16,
  parameter int VEC_W     = 8,
  parameter int LONG_EXP  = 18,
  parameter int SHORT_EXP = 13,
  parameter int SUB_EXP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              rate_short,
  input  logic              cop_dis,
  input  logic              mon_hv_entry,
  input  logic              mon_blank,
  input  logic              tst_hv,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [VEC_W-1:0]  rst_vec_lo,
  output logic              cop_rst_req,
  output logic [VEC_W-1:0]  rd_data
);

  import wdt_pkg::*;

  localparam int CNT_W = LONG_EXP;
  localparam int unsigned LONG_CYC  = timeout_cycles(LONG_EXP, SUB_EXP);
  localparam int unsigned SHORT_CYC = timeout_cycles(SHORT_EXP, SUB_EXP);
  localparam logic [CNT_W-1:0] LONG_T  = CNT_W'(LONG_CYC);
  localparam logic [CNT_W-1:0] SHORT_T = CNT_W'(SHORT_CYC);

  logic      svc;
  logic      run;
  wdt_hold_t hold;

  wdt_bus_port #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_bus (
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .rst_vec_lo (rst_vec_lo),
    .svc        (svc),
    .rd_data    (rd_data)
  );

  wdt_gate u_gate (
    .clk          (clk),
    .por_n        (por_n),
    .cop_dis      (cop_dis),
    .mon_hv_entry (mon_hv_entry),
    .mon_blank    (mon_blank),
    .tst_hv       (tst_hv),
    .hold         (hold),
    .run          (run)
  );

  wdt_count_core #(.CNT_W(CNT_W), .LONG_T(LONG_T), .SHORT_T(SHORT_T)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .svc        (svc),
    .rate_short (rate_short),
    .expire_q   (cop_rst_req)
  );

  // R10: blank-vector monitor with test voltage present never lets a request out
  p_probe_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_blank && tst_hv) |=> !cop_rst_req);

  // R4: read data is zero unless the top address is read
  p_rd_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (rd_data == '0));

  // R8: in reset no request is shown
  always_comb begin
    if (!rst_n) p_reset_quiet_r8: assert (!cop_rst_req || $isunknown(cop_rst_req));
  end

endmodule

// File: tb/wdt_vector_cop_bench.sv
module wdt_vector_cop_bench;

  localparam int LE = 9;
  localparam int SE = 6;
  localparam int UE = 2;
  localparam int LT = (1 << LE) - (1 << UE);
  localparam int ST = (1 << SE) - (1 << UE);
  localparam logic [15:0] TOP = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst_n, por_n, rate_short, cop_dis, mon_hv_entry, mon_blank, tst_hv;
  logic [15:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  rst_vec_lo;
  logic        cop_rst_req;
  logic [7:0]  rd_data;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  wdt_vector_cop #(.ADDR_W(16), .VEC_W(8), .LONG_EXP(LE), .SHORT_EXP(SE), .SUB_EXP(UE))
  u_wdt_vector_cop (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .rate_short(rate_short),
    .cop_dis(cop_dis), .mon_hv_entry(mon_hv_entry), .mon_blank(mon_blank),
    .tst_hv(tst_hv), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .rst_vec_lo(rst_vec_lo), .cop_rst_req(cop_rst_req), .rd_data(rd_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic idle_hits(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (cop_rst_req) hits++;
    end
  endtask

  // One write cycle; called and returns at a falling edge.
  task automatic wr(input logic [15:0] a);
    bus_addr = a;
    bus_wr   = 1'b1;
    step();
    bus_wr   = 1'b0;
  endtask

  // Edges until the request is seen; -1 if it never comes.
  task automatic wait_req(output int n);
    n = -1;
    for (int i = 1; i <= 4 * LT; i++) begin
      step();
      if (cop_rst_req) begin
        n = i;
        break;
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n, h;
    rst_n = 0; por_n = 0; rate_short = 0; cop_dis = 0; mon_hv_entry = 0;
    mon_blank = 0; tst_hv = 0; bus_addr = '0; bus_wr = 0; bus_rd = 0; rst_vec_lo = 8'h00;
    idle(3);
    chk("R8 reset req", int'(cop_rst_req), 0);
    chk("R4 reset rd", int'(rd_data), 0);
    por_n = 1; rst_n = 1;

    // R2 default long period, then R6 periodic repeat
    wait_req(n); chk("R2 long first", n, LT);
    step();      chk("R6 single cycle", int'(cop_rst_req), 0);
    wait_req(n); chk("R6 repeat", n, LT - 1);

    // R1 short period
    rate_short = 1;
    wr(TOP); wait_req(n); chk("R1 short", n, ST);
    wait_req(n); chk("R1 repeat", n, ST);

    // R3 service sweep across the period
    for (int k = 1; k < ST; k += 7) begin
      wr(TOP); idle_hits(k, h); chk("R3 no early req", h, 0);
      wr(TOP); wait_req(n); chk("R3 restart", n, ST);
    end

    // R3 near-miss addresses do nothing
    foreach (bus_addr[b]) begin
      wr(TOP); idle(10);
      wr(TOP ^ (16'h1 << b));
      wait_req(n); chk("R3 other addr", n, ST - 11);
    end

    // R4 read data sweep
    bus_addr = TOP; bus_rd = 1;
    for (int v = 0; v < 256; v++) begin
      rst_vec_lo = 8'(v); #0.5;
      chk("R4 vector", int'(rd_data), v);
    end
    bus_addr = 16'hFFFE; #0.5; chk("R4 other addr", int'(rd_data), 0);
    bus_rd = 0; bus_addr = TOP; #0.5; chk("R4 no strobe", int'(rd_data), 0);

    // R4 reads do not clear
    wr(TOP); bus_rd = 1; idle(20); bus_rd = 0;
    wait_req(n); chk("R4 read keeps count", n, ST - 20);

    // R7 service on the expiry edge wins
    wr(TOP); idle(ST - 1);
    wr(TOP); chk("R7 suppressed", int'(cop_rst_req), 0);
    wait_req(n); chk("R7 full period", n, ST);
    wr(TOP); idle(ST - 1); wait_req(n); chk("R6 expiry edge", n, 1);

    // R5 hold and resume
    wr(TOP); idle(10); cop_dis = 1;
    idle_hits(3 * ST, h); chk("R5 held quiet", h, 0);
    cop_dis = 0; wait_req(n); chk("R5 resume held", n, ST - 10);
    wr(TOP); idle(10); cop_dis = 1; idle(5); wr(TOP); cop_dis = 0;
    wait_req(n); chk("R5 svc while held", n, ST);

    // R8 system reset mid-count
    wr(TOP); idle(30); rst_n = 0; idle(2);
    chk("R8 req low", int'(cop_rst_req), 0);
    rst_n = 1; wait_req(n); chk("R8 full after reset", n, ST);

    // R9 sticky lock
    wr(TOP); mon_hv_entry = 1; step(); mon_hv_entry = 0;
    idle_hits(3 * ST, h); chk("R9 locked", h, 0);
    rst_n = 0; step(); rst_n = 1;
    idle_hits(3 * ST, h); chk("R9 survives rst_n", h, 0);
    por_n = 0; rst_n = 0; step(); por_n = 1; rst_n = 1;
    wait_req(n); chk("R9 cleared by por", n, ST);

    // R10 blank-vector monitor hold is a level
    mon_blank = 1; tst_hv = 1; wr(TOP);
    idle_hits(2 * ST, h); chk("R10 held", h, 0);
    tst_hv = 0; wait_req(n); chk("R10 voltage removed", n, ST);
    mon_blank = 0; tst_hv = 1; wr(TOP);
    wait_req(n); chk("R10 voltage alone", n, ST);
    tst_hv = 0; mon_blank = 1; wr(TOP);
    wait_req(n); chk("R10 blank alone", n, ST);
    mon_blank = 0;

    // R2 long period after a mid-count service
    rate_short = 0; wr(TOP); idle(100); wr(TOP);
    wait_req(n); chk("R2 long after svc", n, LT);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule